// File: doc/BRIEF.md
# Paired-Read General Register File

This block holds the 32 general-purpose 32-bit registers of a processor core. Every read port returns two words each cycle: the register that was named and the register that forms the upper half of a 64-bit floating-point operand with it. The write port accepts either a single 32-bit result or a 64-bit result. A 64-bit result is written as two words over two consecutive clock edges.

Pairing is not uniform. Registers r0 through r15 pair with the next register. Registers above r15 pair with the register two numbers higher. To let one storage location hold both words of any pair, register numbers are renamed to internal slots before storage is touched:

- r0..r15 keep their number.
- The even registers r16..r30 take slots 16..23 in order.
- The odd registers r17..r31 take slots 24..31 in order.

After renaming, the upper word of every pair sits in the next slot. Even slots and odd slots then go to separate RAM banks, and each read port has its own copy of both banks. Four synchronous-read RAMs therefore serve both ports with both words in the same cycle.

Top module: `rfp_pair_rf`

## Requirements
- R1: On each read port, the low output shows the register whose number was on that port's index input at the previous rising edge. The two ports work independently.
- R2: On each read port, the high output shows the pair partner of the indexed register:
  - rX+1 for X from 0 to 15;
  - rX+2 for X from 16 to 29;
  - r17 for r30 (the next slot after r30's slot wraps onto r17's);
  - zero for r31 (its next slot is r0's).
- R3: A write with `wr_en`=1 and `wr_dbl`=0, accepted while `wr_busy` is 0, stores `wr_lo` into register `wr_idx` at that rising edge.
- R4: r0 reads as zero on any output that shows it. A 32-bit write to r0, or the low word of a 64-bit write to r0, leaves it zero.
- R5: A write with `wr_en`=1 and `wr_dbl`=1, accepted while `wr_busy` is 0, works over two rising edges:
  - at the accepting edge, `wr_lo` goes to register `wr_idx`;
  - at the next edge, `wr_hi` goes to the pair partner given in R2.
- R6: `wr_busy` is 1 for exactly the one cycle after a 64-bit write is accepted, and is 0 otherwise.
- R7: Any write request (32-bit or 64-bit) made while `wr_busy` is 1 is ignored.
- R8: A read whose index is sampled at the same edge a word is written returns the newly written word. This applies:
  - in both the low and the high output position;
  - to the delayed high word of a 64-bit write as well.
- R9: While `rst` is 1, all read outputs are zero and `wr_busy` is 0. A high word still pending when reset arrives is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_a_lo | output | 32 | Port A indexed register |
| rd_a_hi | output | 32 | Port A pair-partner register |
| rd_b_lo | output | 32 | Port B indexed register |
| rd_b_hi | output | 32 | Port B pair-partner register |
| wr_en | input | 1 | Write request |
| wr_dbl | input | 1 | 1 selects a 64-bit write |
| wr_idx | input | 5 | Destination register number |
| wr_lo | input | 32 | Word for the destination register |
| wr_hi | input | 32 | Upper word of a 64-bit result |
| wr_busy | output | 1 | High word of a 64-bit write pending |

## Verification
Read data is due one cycle after an index is presented. The bench sets indices on a falling edge and compares at the next falling edge, after exactly one rising edge.

A write becomes visible to an index sampled at the same rising edge. For a 64-bit write, this means the accepting edge for the low word and the following edge for the high word. The bypass checks therefore present the index in the same cycle as the write, or in the busy cycle, and read one falling edge later. `wr_busy` is checked on the two falling edges that follow the request: it must be 1 on the first and 0 on the second.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  // Output source of one read word
  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_BYP  = 2'd1,
    SRC_EVEN = 2'd2,
    SRC_ODD  = 2'd3
  } rfp_src_e;

  // Architectural register number -> internal slot.
  // Below split: identity. At or above split: evens first, then odds.
  function automatic int unsigned arch_to_slot(int unsigned a,
                                               int unsigned nreg,
                                               int unsigned split);
    if (a < split) return a;
    if (((a - split) % 2) == 0) return split + (a - split) / 2;
    return split + (nreg - split) / 2 + (a - split) / 2;
  endfunction

endpackage

// File: rtl/rfp_bank.sv
module rfp_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port RAM, synchronous read (old data on collision)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rfp_wr_ctl.sv
module rfp_wr_ctl #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_dbl,
  input  logic [AW-1:0] wr_slot,
  input  logic [DW-1:0] wr_lo,
  input  logic [DW-1:0] wr_hi,
  output logic          we,
  output logic [AW-1:0] widx,
  output logic [DW-1:0] wdata,
  output logic          busy
);
  logic          pend_q;
  logic [AW-1:0] pend_slot_q;
  logic [DW-1:0] pend_data_q;
  logic          accept;

  assign accept = wr_en && !pend_q && !rst;
  assign busy   = pend_q;

  // One effective write per cycle: pending high word has priority
  always_comb begin
    if (pend_q) begin
      we    = !rst && (pend_slot_q != '0);
      widx  = pend_slot_q;
      wdata = pend_data_q;
    end else begin
      we    = accept && (wr_slot != '0);
      widx  = wr_slot;
      wdata = wr_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_slot_q <= '0;
      pend_data_q <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end else if (accept && wr_dbl) begin
      pend_q      <= 1'b1;
      pend_slot_q <= wr_slot + AW'(1);
      pend_data_q <= wr_hi;
    end
  end
endmodule

// File: rtl/rfp_rd_port.sv
module rfp_rd_port #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int BAW = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] slot_lo,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);
  import rfp_pkg::*;

  logic [AW-1:0]  slot_hi;
  logic [BAW-1:0] baddr [2];
  logic [DW-1:0]  bdata [2];
  rfp_src_e       src_lo_d, src_hi_d, src_lo_q, src_hi_q;
  logic [DW-1:0]  byp_q;

  assign slot_hi = slot_lo + AW'(1);

  // Bank 0 holds even slots, bank 1 holds odd slots
  assign baddr[0] = slot_lo[0] ? slot_hi[AW-1:1] : slot_lo[AW-1:1];
  assign baddr[1] = slot_lo[0] ? slot_lo[AW-1:1] : slot_hi[AW-1:1];

  for (genvar p = 0; p < 2; p++) begin : g_bank
    rfp_bank #(.DW(DW), .DEPTH(NREG / 2)) u_bank (
      .clk   (clk),
      .we    (we && (widx[0] == 1'(p))),
      .waddr (widx[AW-1:1]),
      .wdata (wdata),
      .raddr (baddr[p]),
      .rdata (bdata[p])
    );
  end

  function automatic rfp_src_e pick(logic r, logic w, logic [AW-1:0] wi,
                                    logic [AW-1:0] s);
    if (r || s == '0) return SRC_ZERO;
    if (w && wi == s) return SRC_BYP;
    return s[0] ? SRC_ODD : SRC_EVEN;
  endfunction

  assign src_lo_d = pick(rst, we, widx, slot_lo);
  assign src_hi_d = pick(rst, we, widx, slot_hi);

  always_ff @(posedge clk) begin
    src_lo_q <= src_lo_d;
    src_hi_q <= src_hi_d;
    byp_q    <= wdata;
  end

  function automatic logic [DW-1:0] sel(rfp_src_e s, logic [DW-1:0] b,
                                        logic [DW-1:0] e, logic [DW-1:0] o);
    case (s)
      SRC_BYP:  return b;
      SRC_EVEN: return e;
      SRC_ODD:  return o;
      default:  return '0;
    endcase
  endfunction

  assign lo = sel(src_lo_q, byp_q, bdata[0], bdata[1]);
  assign hi = sel(src_hi_q, byp_q, bdata[0], bdata[1]);
endmodule

// File: rtl/rfp_pair_rf.sv
module rfp_pair_rf #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW    = $clog2(NREG),
  localparam int SPLIT = NREG / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a_lo,
  output logic [DW-1:0] rd_a_hi,
  output logic [DW-1:0] rd_b_lo,
  output logic [DW-1:0] rd_b_hi,
  input  logic          wr_en,
  input  logic          wr_dbl,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_lo,
  input  logic [DW-1:0] wr_hi,
  output logic          wr_busy
);
  import rfp_pkg::*;

  localparam int NPORT = 2;

  logic [AW-1:0] rd_idx  [NPORT];
  logic [AW-1:0] rd_slot [NPORT];
  logic [DW-1:0] rd_lo   [NPORT];
  logic [DW-1:0] rd_hi   [NPORT];
  logic [AW-1:0] wr_slot;
  logic          we;
  logic [AW-1:0] widx;
  logic [DW-1:0] wdata;

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;
  assign wr_slot   = AW'(arch_to_slot(32'(wr_idx), NREG, SPLIT));

  rfp_wr_ctl #(.DW(DW), .AW(AW)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_dbl  (wr_dbl),
    .wr_slot (wr_slot),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .we      (we),
    .widx    (widx),
    .wdata   (wdata),
    .busy    (wr_busy)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign rd_slot[p] = AW'(arch_to_slot(32'(rd_idx[p]), NREG, SPLIT));
    rfp_rd_port #(.DW(DW), .NREG(NREG)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .slot_lo (rd_slot[p]),
      .we      (we),
      .widx    (widx),
      .wdata   (wdata),
      .lo      (rd_lo[p]),
      .hi      (rd_hi[p])
    );
  end

  assign rd_a_lo = rd_lo[0];
  assign rd_a_hi = rd_hi[0];
  assign rd_b_lo = rd_lo[1];
  assign rd_b_hi = rd_hi[1];
endmodule

// File: rtl/rfp_pair_rf_chk.sv
module rfp_pair_rf_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_a_idx,
  input logic [AW-1:0] rd_b_idx,
  input logic [DW-1:0] rd_a_lo,
  input logic [DW-1:0] rd_a_hi,
  input logic [DW-1:0] rd_b_lo,
  input logic          wr_en,
  input logic          wr_dbl,
  input logic [AW-1:0] wr_idx,
  input logic [DW-1:0] wr_lo,
  input logic          wr_busy
);
  p_busy_after_dbl_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dbl && !wr_busy) |=> wr_busy);

  p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> !wr_busy);

  p_busy_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(wr_en && wr_dbl));

  p_zero_a_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rd_a_idx == '0) |-> (rd_a_lo == '0));

  p_zero_b_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rd_b_idx == '0) |-> (rd_b_lo == '0));

  p_r31_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_a_idx == '1) |-> (rd_a_hi == '0));

  p_bypass_lo_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en && !wr_dbl && !wr_busy && wr_idx == rd_a_idx &&
          wr_idx != '0) |-> (rd_a_lo == $past(wr_lo)));
endmodule

bind rfp_pair_rf rfp_pair_rf_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_a_idx (rd_a_idx),
  .rd_b_idx (rd_b_idx),
  .rd_a_lo  (rd_a_lo),
  .rd_a_hi  (rd_a_hi),
  .rd_b_lo  (rd_b_lo),
  .wr_en    (wr_en),
  .wr_dbl   (wr_dbl),
  .wr_idx   (wr_idx),
  .wr_lo    (wr_lo),
  .wr_busy  (wr_busy)
);

// File: tb/rfp_pair_rf_tb.sv
module rfp_pair_rf_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_lo, rd_a_hi, rd_b_lo, rd_b_hi, wr_lo, wr_hi;
  logic        wr_en, wr_dbl, wr_busy;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] m [32];

  always #2 clk = ~clk;

  rfp_pair_rf u_dut (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_lo(rd_a_lo), .rd_a_hi(rd_a_hi), .rd_b_lo(rd_b_lo), .rd_b_hi(rd_b_hi),
    .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_busy(wr_busy)
  );

  function automatic int partner(int a);
    if (a <= 15) return a + 1;
    if (a <= 29) return a + 2;
    if (a == 30) return 17;
    return 0;
  endfunction

  function automatic logic [31:0] mval(int a);
    return (a == 0) ? 32'h0 : m[a];
  endfunction

  function automatic logic [31:0] pat(int a, int k);
    return (32'(k) * 32'h1357_9BDF) ^ (32'(a) * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, int b, string tag);
    @(negedge clk);
    rd_a_idx = 5'(a); rd_b_idx = 5'(b);
    @(negedge clk);
    chk({tag, " R1 port A lo"}, rd_a_lo, mval(a));
    chk({tag, " R2 port A hi"}, rd_a_hi, mval(partner(a)));
    chk({tag, " R1 port B lo"}, rd_b_lo, mval(b));
    chk({tag, " R2 port B hi"}, rd_b_hi, mval(partner(b)));
  endtask

  task automatic w32(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'(a); wr_lo = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 0) m[a] = d;
  endtask

  task automatic w64(int a, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'(a); wr_lo = lo; wr_hi = hi;
    @(negedge clk);
    wr_en = 1'b0; wr_dbl = 1'b0;
    chk("R6 busy after 64-bit accept", 32'(wr_busy), 32'd1);
    @(negedge clk);
    chk("R6 busy drops", 32'(wr_busy), 32'd0);
    if (a != 0) m[a] = lo;
    if (partner(a) != 0) m[partner(a)] = hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_dbl = 1'b0; wr_idx = '0;
    wr_lo = '0; wr_hi = '0; rd_a_idx = 5'd3; rd_b_idx = 5'd20;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset a_lo", rd_a_lo, 32'h0);
    chk("R9 reset a_hi", rd_a_hi, 32'h0);
    chk("R9 reset b_lo", rd_b_lo, 32'h0);
    chk("R9 reset b_hi", rd_b_hi, 32'h0);
    chk("R9 reset busy", 32'(wr_busy), 32'd0);
    rst = 1'b0;

    // R3: fill every register with 32-bit writes (r0 attempt included, R4)
    for (int a = 0; a < 32; a++) w32(a, pat(a, 1));
    for (int a = 0; a < 32; a++) rd(a, 31 - a, "sweep32");

    // R5: 64-bit writes over every destination
    for (int a = 1; a < 32; a++) begin
      w64(a, pat(a, 2), pat(a, 3));
      rd(a, partner(a), "sweep64");
    end
    for (int a = 0; a < 32; a++) rd(a, (a + 7) % 32, "resweep");

    // R8: same-cycle bypass, low position on A and high position on B
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd5; wr_lo = 32'hCAFE_0005;
    rd_a_idx = 5'd5; rd_b_idx = 5'd4;
    @(negedge clk);
    wr_en = 1'b0; m[5] = 32'hCAFE_0005;
    chk("R8 bypass lo", rd_a_lo, 32'hCAFE_0005);
    chk("R8 bypass hi", rd_b_hi, 32'hCAFE_0005);

    // R8: bypass of the delayed high word (r20 pairs with r22)
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd20;
    wr_lo = 32'h1111_2020; wr_hi = 32'h2222_2222;
    @(negedge clk);
    wr_en = 1'b0; wr_dbl = 1'b0; rd_a_idx = 5'd22; rd_b_idx = 5'd20;
    @(negedge clk);
    m[20] = 32'h1111_2020; m[22] = 32'h2222_2222;
    chk("R8 pending-high bypass lo", rd_a_lo, 32'h2222_2222);
    chk("R8 pending-high bypass hi", rd_b_hi, 32'h2222_2222);
    chk("R5 low word of r20", rd_b_lo, 32'h1111_2020);

    // R7: writes during busy are ignored
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd2;
    wr_lo = 32'h0202_0202; wr_hi = 32'h0303_0303;
    @(negedge clk);
    wr_dbl = 1'b1; wr_idx = 5'd9; wr_lo = 32'hDEAD_0009; wr_hi = 32'hDEAD_000A;
    @(negedge clk);
    wr_en = 1'b0; wr_dbl = 1'b0;
    m[2] = 32'h0202_0202; m[3] = 32'h0303_0303;
    chk("R7 no busy from ignored request", 32'(wr_busy), 32'd0);
    rd(9, 2, "R7 ignored");

    // R4: r0 stays zero, r31 high is zero
    w32(0, 32'hFFFF_FFFF);
    rd(0, 31, "R4 r0");
    w64(0, 32'h7777_7777, 32'h0101_0001);
    rd(0, 1, "R4 r0 dbl");

    // R9: reset during the pending cycle drops the high word (r6 -> r7)
    @(negedge clk);
    wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd6;
    wr_lo = 32'h0606_0606; wr_hi = 32'hBAD0_0007;
    @(negedge clk);
    wr_en = 1'b0; wr_dbl = 1'b0; rst = 1'b1; m[6] = 32'h0606_0606;
    @(negedge clk);
    chk("R9 busy cleared", 32'(wr_busy), 32'd0);
    chk("R9 outputs zero in reset", rd_a_lo, 32'h0);
    rst = 1'b0;
    rd(6, 7, "R9 dropped high");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule